// File: doc/BRIEF.md
# Interrupt Fetch Redirect Controller

This block sits next to a three-stage fetch, decode and execute pipeline. It decides when an interrupt may be taken. When it accepts one, it steers the next two instruction fetches away from the program counter. They go instead to a two-word fast routine located at a vector address. The first of these fetches reads the vector address and the second reads the vector address plus one. After that, fetching returns to the program counter.

Each fetch arrives with a three-bit class code from the instruction predecoder. The block uses this code to decide whether the word fetched in the accept cycle must be thrown away and fetched again after the routine returns. That word is thrown away when it is a one-word change-of-flow instruction, or when it is the first half of a two-word instruction whose second half the redirect displaces. The block also computes the return address to be saved. Acceptance is held off in three situations: around uninterruptible instructions, inside a repeat package, and until enough instructions have been decoded since the previous interrupt routine entered decode.

Top module: `irq_fetch_redirect`

## Requirements
- R1: After reset, fetch_sel_o is 0 (program counter), abort_o is 0, ret_pc_o is 0 and irq_ack_o is 0. An interrupt may be accepted on the first eligible fetch after reset, with no spacing wait.
- R2: irq_ack_o is high, in the same cycle, exactly when all of the following hold: irq_req_i is high, fetch_valid_i is high, no redirect is in progress, the spacing rule of R8 is met, and the fetch is not blocked by R7.
- R3: fetch_sel_o encodes 0 = program counter, 1 = first vector word, 2 = second vector word. In the cycle after irq_ack_o, fetch_sel_o is 1 and irq_addr_o equals the vec_addr_i captured at acceptance. In the next cycle, fetch_sel_o is 2 and irq_addr_o is that address plus one. After that, fetch_sel_o returns to 0. irq_addr_o is 0 whenever fetch_sel_o is 0.
- R4: If the word fetched in the accept cycle has class 1 (one-word change of flow) or class 2 (first word of a two-word instruction), abort_o is high during the first-vector-word cycle only, and ret_pc_o equals that word's fetch_pc_i.
- R5: If the accepted fetch has class 0 (normal one-word), class 3 (second word of two), or class 6 or 7 (treated as normal), abort_o stays low and ret_pc_o equals fetch_pc_i plus one, wrapping modulo 2^ADDR_W.
- R6: ret_pc_o is updated only in the cycle after an acceptance. Otherwise it holds its value.
- R7: No acceptance occurs on a fetch of class 5 (uninterruptible) or class 4 (repeat). No acceptance occurs on the next valid fetch after a repeat fetch, which is the instruction being repeated.
- R8: The cycle in which fetch_sel_o is 2 is the cycle in which the first vector word sits in decode. That cycle clears the spacing count, and a dec_valid_i pulse in that same cycle is not counted. A new acceptance then requires at least SPACING (default 4) dec_valid_i pulses after that cycle.
- R9: No acceptance occurs while fetch_sel_o is not 0, or while fetch_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 1 | Arbitrated interrupt request, held until acknowledged |
| vec_addr_i | input | ADDR_W | Start address of the fast routine |
| fetch_valid_i | input | 1 | A program-counter fetch takes place this cycle |
| fetch_pc_i | input | ADDR_W | Address of the word fetched this cycle |
| fetch_class_i | input | 3 | Class code of the word fetched this cycle |
| dec_valid_i | input | 1 | One instruction enters decode this cycle |
| irq_ack_o | output | 1 | Interrupt accepted this cycle |
| fetch_sel_o | output | 2 | Fetch address source: 0 PC, 1 vector, 2 vector+1 |
| irq_addr_o | output | ADDR_W | Fetch address when a vector word is selected |
| abort_o | output | 1 | Word fetched in the accept cycle is discarded and refetched |
| ret_pc_o | output | ADDR_W | Return address to save for the routine |

## Verification
A vector table drives every class code through acceptance. A design that aborted second-word or normal fetches would return to the wrong address and skip or duplicate an instruction. Blocked classes must leave the return address untouched. The spacing test places one decode pulse inside the cycle where the first vector word is in decode, then supplies one pulse too few. A counter that counted that pulse, or cleared one cycle late, would accept early. Other tests fetch a normal word right after a repeat fetch, raise a request while a redirect is in progress, and use an address at the top of the range so that a return address that fails to wrap shows up.

// File: rtl/irq_inj_pkg.sv
package irq_inj_pkg;
  localparam logic [2:0] CLS_NORM  = 3'd0;
  localparam logic [2:0] CLS_COF   = 3'd1;
  localparam logic [2:0] CLS_W2A   = 3'd2;
  localparam logic [2:0] CLS_W2B   = 3'd3;
  localparam logic [2:0] CLS_REP   = 3'd4;
  localparam logic [2:0] CLS_UNINT = 3'd5;

  typedef enum logic [1:0] {
    SEL_PC   = 2'd0,
    SEL_VEC0 = 2'd1,
    SEL_VEC1 = 2'd2
  } fetch_sel_e;
endpackage

// File: rtl/inj_spacing.sv
module inj_spacing #(
  parameter int SPACING = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic count_i,
  output logic ok_o
);
  localparam int CW = $clog2(SPACING + 1);
  localparam logic [CW-1:0] CAP = CW'(SPACING);

  logic [CW-1:0] cnt_q;

  // starts saturated so the first interrupt after reset is not delayed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= CAP;
    else if (clear_i)             cnt_q <= '0;
    else if (count_i && cnt_q < CAP) cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q >= CAP);

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CAP);
  assert_clear_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !ok_o);
endmodule

// File: rtl/inj_gate.sv
module inj_gate
  import irq_inj_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fetch_valid_i,
  input  logic [2:0] fetch_class_i,
  output logic       blk_o
);
  logic rep_prev_q;

  // the fetch after a repeat is the repeated instruction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rep_prev_q <= 1'b0;
    else if (fetch_valid_i) rep_prev_q <= (fetch_class_i == CLS_REP);
  end

  assign blk_o = rep_prev_q || (fetch_class_i == CLS_REP) || (fetch_class_i == CLS_UNINT);

  assert_rep_shadow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_class_i == CLS_REP) |=> blk_o);
endmodule

// File: rtl/inj_abort.sv
module inj_abort
  import irq_inj_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [2:0]        fetch_class_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              abort_o,
  output logic [ADDR_W-1:0] ret_pc_o
);
  always_comb begin
    abort_o  = (fetch_class_i == CLS_COF) || (fetch_class_i == CLS_W2A);
    ret_pc_o = abort_o ? fetch_pc_i : fetch_pc_i + ADDR_W'(1);
  end
endmodule

// File: rtl/irq_fetch_redirect.sv
module irq_fetch_redirect
  import irq_inj_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SPACING = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic [ADDR_W-1:0] vec_addr_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic [2:0]        fetch_class_i,
  input  logic              dec_valid_i,
  output logic              irq_ack_o,
  output logic [1:0]        fetch_sel_o,
  output logic [ADDR_W-1:0] irq_addr_o,
  output logic              abort_o,
  output logic [ADDR_W-1:0] ret_pc_o
);
  fetch_sel_e        state_q, state_d;
  logic [ADDR_W-1:0] vec_q, ret_q, ret_calc;
  logic              abort_q, abort_need, space_ok, blk, go;

  inj_spacing #(.SPACING(SPACING)) u_spacing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_q == SEL_VEC1),
    .count_i (dec_valid_i),
    .ok_o    (space_ok)
  );

  inj_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_valid_i (fetch_valid_i),
    .fetch_class_i (fetch_class_i),
    .blk_o         (blk)
  );

  inj_abort #(.ADDR_W(ADDR_W)) u_abort (
    .fetch_class_i (fetch_class_i),
    .fetch_pc_i    (fetch_pc_i),
    .abort_o       (abort_need),
    .ret_pc_o      (ret_calc)
  );

  assign go = irq_req_i && fetch_valid_i && (state_q == SEL_PC) && space_ok && !blk;

  always_comb begin
    unique case (state_q)
      SEL_PC:   state_d = go ? SEL_VEC0 : SEL_PC;
      SEL_VEC0: state_d = SEL_VEC1;
      default:  state_d = SEL_PC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEL_PC;
      vec_q   <= '0;
      ret_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= go && abort_need;
      if (go) begin
        vec_q <= vec_addr_i;
        ret_q <= ret_calc;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      SEL_VEC0: irq_addr_o = vec_q;
      SEL_VEC1: irq_addr_o = vec_q + ADDR_W'(1);
      default:  irq_addr_o = '0;
    endcase
  end

  assign irq_ack_o   = go;
  assign fetch_sel_o = state_q;
  assign abort_o     = abort_q;
  assign ret_pc_o    = ret_q;

  assert_redirect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> (fetch_sel_o == SEL_VEC0 && irq_addr_o == $past(vec_addr_i)));
  assert_second_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_sel_o == SEL_VEC0) |=> (fetch_sel_o == SEL_VEC1 && irq_addr_o == $past(irq_addr_o) + ADDR_W'(1)));
  assert_abort_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (fetch_sel_o == SEL_VEC0));
  assert_abort_cof_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o && fetch_class_i == CLS_COF) |=> (abort_o && ret_pc_o == $past(fetch_pc_i)));
  assert_ret_next_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o && (fetch_class_i == CLS_NORM || fetch_class_i == CLS_W2B))
      |=> (!abort_o && ret_pc_o == $past(fetch_pc_i) + ADDR_W'(1)));
  assert_ret_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_ack_o |=> $stable(ret_pc_o));
  assert_no_unint_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> (fetch_class_i != CLS_UNINT && fetch_class_i != CLS_REP));
  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_sel_o != SEL_PC || !fetch_valid_i) |-> !irq_ack_o);
endmodule

// File: tb/irq_fetch_redirect_bench.sv
module irq_fetch_redirect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          irq_req_i = 1'b0;
  logic [AW-1:0] vec_addr_i = '0;
  logic          fetch_valid_i = 1'b0;
  logic [AW-1:0] fetch_pc_i = '0;
  logic [2:0]    fetch_class_i = '0;
  logic          dec_valid_i = 1'b0;
  logic          irq_ack_o;
  logic [1:0]    fetch_sel_o;
  logic [AW-1:0] irq_addr_o;
  logic          abort_o;
  logic [AW-1:0] ret_pc_o;

  int total = 0;
  int bad = 0;
  logic [AW-1:0] last_ret = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_fetch_redirect #(.ADDR_W(AW), .SPACING(4)) u_irq_fetch_redirect (
    .clk_i, .rst_ni, .irq_req_i, .vec_addr_i, .fetch_valid_i, .fetch_pc_i,
    .fetch_class_i, .dec_valid_i, .irq_ack_o, .fetch_sel_o, .irq_addr_o,
    .abort_o, .ret_pc_o
  );

  typedef struct packed {
    logic [2:0]    cls;
    logic [AW-1:0] pc;
    logic [AW-1:0] vec;
    logic          ack;
    logic          ab;
    logic [AW-1:0] ret;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 16'h0100, 16'h0040, 1'b1, 1'b0, 16'h0101},
    '{3'd1, 16'h0200, 16'h0044, 1'b1, 1'b1, 16'h0200},
    '{3'd2, 16'h0300, 16'h0048, 1'b1, 1'b1, 16'h0300},
    '{3'd3, 16'h0301, 16'h004C, 1'b1, 1'b0, 16'h0302},
    '{3'd4, 16'h0400, 16'h0060, 1'b0, 1'b0, 16'h0000},
    '{3'd5, 16'h0500, 16'h0064, 1'b0, 1'b0, 16'h0000},
    '{3'd7, 16'hFFFF, 16'h0050, 1'b1, 1'b0, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #(CLK_PERIOD/4);
  endtask

  task automatic dec_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      dec_valid_i = 1'b1;
      tick();
    end
    dec_valid_i = 1'b0;
  endtask

  task automatic plain_fetch(input logic [2:0] cls);
    irq_req_i = 1'b0;
    fetch_valid_i = 1'b1;
    fetch_class_i = cls;
    tick();
    fetch_valid_i = 1'b0;
  endtask

  // run a full accepted redirect from an accept-ready state
  task automatic take_irq(input logic [AW-1:0] pc, input logic [AW-1:0] vec);
    irq_req_i = 1'b1; fetch_valid_i = 1'b1; fetch_class_i = 3'd0;
    fetch_pc_i = pc; vec_addr_i = vec;
    #1;
    chk("R2 ack", irq_ack_o, 1);
    tick();
    irq_req_i = 1'b0; fetch_valid_i = 1'b0;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #(CLK_PERIOD/4);
    // R1 reset state
    chk("R1 sel", fetch_sel_o, 0);
    chk("R1 abort", abort_o, 0);
    chk("R1 ret", ret_pc_o, 0);
    chk("R1 ack", irq_ack_o, 0);
    rst_ni = 1'b1;
    tick();

    // R1/R2/R3/R4/R5/R6/R7 vector table; first entry needs no spacing wait
    for (int v = 0; v < NV; v++) begin
      irq_req_i = 1'b1; fetch_valid_i = 1'b1;
      fetch_class_i = TBL[v].cls; fetch_pc_i = TBL[v].pc; vec_addr_i = TBL[v].vec;
      #1;
      chk("R2 R7 ack", irq_ack_o, TBL[v].ack);
      tick();
      irq_req_i = 1'b0; fetch_valid_i = 1'b0;
      #1;
      if (TBL[v].ack) begin
        chk("R3 sel first", fetch_sel_o, 1);
        chk("R3 addr first", irq_addr_o, TBL[v].vec);
        chk("R4 R5 abort", abort_o, TBL[v].ab);
        chk("R4 R5 ret", ret_pc_o, TBL[v].ret);
        last_ret = TBL[v].ret;
        tick();
        chk("R3 sel second", fetch_sel_o, 2);
        chk("R3 addr second", irq_addr_o, TBL[v].vec + 16'd1);
        chk("R4 abort one cycle", abort_o, 0);
        chk("R6 ret held", ret_pc_o, last_ret);
        tick();
        chk("R3 sel back", fetch_sel_o, 0);
        chk("R3 addr idle", irq_addr_o, 0);
        dec_pulses(4);
      end else begin
        chk("R7 sel stays", fetch_sel_o, 0);
        chk("R6 ret unchanged", ret_pc_o, last_ret);
      end
      plain_fetch(3'd0);
    end

    // R8 spacing: pulse in decode cycle of first vector word is ignored
    irq_req_i = 1'b1; fetch_valid_i = 1'b1; fetch_class_i = 3'd0;
    fetch_pc_i = 16'h0700; vec_addr_i = 16'h0080;
    #1;
    chk("R2 ack spacing setup", irq_ack_o, 1);
    tick();
    irq_req_i = 1'b0; fetch_valid_i = 1'b0;
    // R9 request while redirect in progress
    irq_req_i = 1'b1; fetch_valid_i = 1'b1;
    #1;
    chk("R9 no ack while busy", irq_ack_o, 0);
    tick();
    dec_valid_i = 1'b1;   // cycle with fetch_sel_o == 2
    #1;
    chk("R8 sel second", fetch_sel_o, 2);
    chk("R9 no ack on second word", irq_ack_o, 0);
    irq_req_i = 1'b0; fetch_valid_i = 1'b0;
    tick();
    dec_valid_i = 1'b0;
    dec_pulses(3);
    irq_req_i = 1'b1; fetch_valid_i = 1'b1; fetch_class_i = 3'd0;
    #1;
    chk("R8 three decodes not enough", irq_ack_o, 0);
    fetch_valid_i = 1'b0;
    irq_req_i = 1'b0;
    dec_pulses(1);
    irq_req_i = 1'b1;
    #1;
    chk("R9 no ack without fetch", irq_ack_o, 0);
    fetch_valid_i = 1'b1;
    #1;
    chk("R8 fourth decode allows", irq_ack_o, 1);
    tick();
    irq_req_i = 1'b0; fetch_valid_i = 1'b0;
    tick(); tick();
    dec_pulses(4);

    // R7 the fetch after a repeat is blocked, the one after that is not
    plain_fetch(3'd4);
    irq_req_i = 1'b1; fetch_valid_i = 1'b1; fetch_class_i = 3'd0; fetch_pc_i = 16'h0901;
    #1;
    chk("R7 repeated instr blocked", irq_ack_o, 0);
    tick();
    fetch_pc_i = 16'h0902;
    #1;
    chk("R7 after package ok", irq_ack_o, 1);
    tick();
    irq_req_i = 1'b0; fetch_valid_i = 1'b0;
    #1;
    chk("R5 ret after package", ret_pc_o, 16'h0903);
    tick(); tick();
    dec_pulses(4);
    take_irq(16'h0A00, 16'h00A0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule